// File: doc/BRIEF.md
# Alternating Frame Store with Serial Readout

This block holds formatted row records for a whole frame in one of two equal memory banks while the other bank is sent out serially. A one-cycle frame-start marker swaps the roles of the banks. From then on, new words fill the bank that has just been released. The bank that was just filled is then emitted as a framed record. That record is made of a fixed header word, a frame number, the stored words in write order, and a trailer word that carries the stored word count. Once the trailer has gone out, padding words follow until the next marker, so the serial stream never pauses.

Serial output uses either one lane at one bit per cycle, or two lanes that each carry half the bits of every word, which halves the time per word. The marker is never held back by unsent data. If the read side had not finished its frame, that frame is cut short and a status bit reports the cut until the next marker. Writes beyond the capacity of a bank are dropped, and a full flag stays set for the rest of that frame. With the default depth of 3072 sixteen-bit words per bank, the total storage is 96 kbit.

Top module: `pingpong_serial_buffer`

## Requirements
- R1: While reset is high, `lane0`, `lane1`, `frame_mark`, `trunc` and `buf_full` are all 0.
- R2: A `frame_start` pulse sampled at a clock edge makes the next output frame begin right after that edge, and its first word is the header word `HDR_WORD` (default 16'hF0C5).
- R3: Each output frame consists of the header, then a frame-number word equal to the count of `frame_start` pulses since reset (1 for the first frame), then the stored words in the order they were written, then a trailer word with 4'hE in bits 15:12 and the stored word count in bits 11:0.
- R4: Words written after marker k are emitted in the frame that starts at marker k+1. A word written in the same cycle as a marker belongs to the new frame's bank and is its first word.
- R5: Once the trailer has been sent, the output carries `PAD_WORD` (default 16'h3A3A) words back to back until the next marker.
- R6: When one-lane mode is selected (`two_lane`=0), each word takes 16 cycles on `lane0`, most significant bit first, and `lane1` stays 0.
- R7: When two-lane mode is selected (`two_lane`=1), each word takes 8 cycles. In each cycle `lane1` carries an odd bit and `lane0` the even bit just below it, starting with bits 15 and 14. The mode is sampled at the start of every word.
- R8: Writes beyond `DEPTH` words in one frame are discarded and `buf_full` becomes 1 in the cycle after the first discarded write. It stays 1 until the next marker and is 0 after the marker. The trailer then reports `DEPTH` words.
- R9: A marker that arrives before the current trailer has been completely sent cuts the frame short and sets `trunc` to 1. A marker that arrives later sets `trunc` to 0. `trunc` keeps its value between markers.
- R10: `frame_mark` is 1 for exactly the one cycle in which the first bit of a header appears on the lanes, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both write and read sides |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle marker that swaps the banks |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | WORD_W | Record word to store |
| two_lane | input | 1 | 1 selects two-lane output, 0 selects one lane |
| lane0 | output | 1 | Serial lane 0 (the only lane in one-lane mode, even bits in two-lane mode) |
| lane1 | output | 1 | Serial lane 1 (odd bits in two-lane mode, 0 otherwise) |
| frame_mark | output | 1 | High while the first header bit is on the lanes |
| trunc | output | 1 | The last marker cut an unfinished frame |
| buf_full | output | 1 | A write was dropped in the current frame |

## Verification
The bench builds the block with `DEPTH` set to 8, so that a single frame of eleven writes is enough to overrun a bank and drive the trailer count to its ceiling. It also keeps a whole framed readout short enough that a marker can be placed either after the trailer or in the middle of the data. With that small depth, both the clean swap and the truncating swap fit into a few hundred cycles, in both lane modes. It also covers a write made in the same cycle as a marker.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    PH_HDR,
    PH_CNT,
    PH_DAT,
    PH_TRL,
    PH_PAD
  } phase_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 3072,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl #(
  parameter int DEPTH = 3072,
  parameter int AW    = 12,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          wr_valid,
  output logic          wbank,
  output logic          wsel,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] wcount,
  output logic          buf_full
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  logic room;

  always_comb begin
    room  = wcount < DEPTH_C;
    wsel  = frame_start ? ~wbank : wbank;
    waddr = frame_start ? '0 : wcount[AW-1:0];
    we    = wr_valid & (frame_start | room);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank    <= 1'b0;
      wcount   <= '0;
      buf_full <= 1'b0;
    end else if (frame_start) begin
      wbank    <= ~wbank;
      wcount   <= wr_valid ? CW'(1) : '0;
      buf_full <= 1'b0;
    end else if (wr_valid) begin
      if (room) wcount   <= wcount + CW'(1);
      else      buf_full <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_serial.sv
module pp_serial
  import pp_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          AW       = 12,
  parameter int          CW       = 12,
  parameter logic [15:0] HDR_WORD = 16'hF0C5,
  parameter logic [15:0] PAD_WORD = 16'h3A3A,
  parameter logic [3:0]  TRL_TAG  = 4'hE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap,
  input  logic          two_lane,
  input  logic [CW-1:0] load_len,
  input  logic [W-1:0]  rdata,
  output logic [AW-1:0] raddr,
  output logic          lane0,
  output logic          lane1,
  output logic          frame_mark,
  output logic          trunc
);
  localparam int SW = $clog2(W);
  localparam int LW = W - 4;

  phase_t        ph, nxt_ph;
  logic [W-1:0]  sh, nxt_word;
  logic [SW-1:0] slot;
  logic          mode_q, last, adv;
  logic [CW-1:0] idx, len;
  logic [W-1:0]  fcnt;
  logic [W-1:0]  trl_word;

  assign last     = (slot == '0);
  assign raddr    = idx[AW-1:0];
  assign trl_word = {TRL_TAG, LW'(len)};

  always_comb begin
    nxt_word = PAD_WORD;
    nxt_ph   = PH_PAD;
    adv      = 1'b0;
    if (swap) begin
      nxt_word = HDR_WORD;
      nxt_ph   = PH_HDR;
    end else begin
      unique case (ph)
        PH_HDR: begin
          nxt_word = fcnt;
          nxt_ph   = PH_CNT;
        end
        PH_CNT, PH_DAT: begin
          if (idx < len) begin
            nxt_word = rdata;
            nxt_ph   = PH_DAT;
            adv      = 1'b1;
          end else begin
            nxt_word = trl_word;
            nxt_ph   = PH_TRL;
          end
        end
        default: begin
          nxt_word = PAD_WORD;
          nxt_ph   = PH_PAD;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_PAD;
      sh         <= '0;
      slot       <= '0;
      mode_q     <= 1'b0;
      idx        <= '0;
      len        <= '0;
      fcnt       <= '0;
      lane0      <= 1'b0;
      lane1      <= 1'b0;
      frame_mark <= 1'b0;
      trunc      <= 1'b0;
    end else begin
      frame_mark <= swap;
      if (swap) begin
        trunc <= !(ph == PH_PAD || (ph == PH_TRL && last));
        fcnt  <= fcnt + W'(1);
        len   <= load_len;
        idx   <= '0;
      end else if (last && adv) begin
        idx <= idx + CW'(1);
      end
      if (swap || last) begin
        ph     <= nxt_ph;
        mode_q <= two_lane;
        if (two_lane) begin
          lane1 <= nxt_word[W-1];
          lane0 <= nxt_word[W-2];
          sh    <= nxt_word << 2;
          slot  <= SW'(W/2 - 1);
        end else begin
          lane1 <= 1'b0;
          lane0 <= nxt_word[W-1];
          sh    <= nxt_word << 1;
          slot  <= SW'(W - 1);
        end
      end else begin
        slot <= slot - SW'(1);
        if (mode_q) begin
          lane1 <= sh[W-1];
          lane0 <= sh[W-2];
          sh    <= sh << 2;
        end else begin
          lane1 <= 1'b0;
          lane0 <= sh[W-1];
          sh    <= sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/pingpong_serial_buffer.sv
module pingpong_serial_buffer #(
  parameter int          WORD_W   = 16,
  parameter int          DEPTH    = 3072,
  parameter logic [15:0] HDR_WORD = 16'hF0C5,
  parameter logic [15:0] PAD_WORD = 16'h3A3A,
  parameter logic [3:0]  TRL_TAG  = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              two_lane,
  output logic              lane0,
  output logic              lane1,
  output logic              frame_mark,
  output logic              trunc,
  output logic              buf_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic              wbank, wsel, we;
  logic [AW-1:0]     waddr, raddr;
  logic [CW-1:0]     wcount;
  logic [WORD_W-1:0] q [2];
  logic [WORD_W-1:0] rdata;

  pp_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_valid(wr_valid),
    .wbank(wbank), .wsel(wsel), .we(we), .waddr(waddr), .wcount(wcount),
    .buf_full(buf_full)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_bank #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk(clk), .we(we && (wsel == 1'(b))), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(q[b])
    );
  end

  // the bank not being written is the one being read
  assign rdata = wbank ? q[0] : q[1];

  pp_serial #(
    .W(WORD_W), .AW(AW), .CW(CW),
    .HDR_WORD(HDR_WORD), .PAD_WORD(PAD_WORD), .TRL_TAG(TRL_TAG)
  ) u_ser (
    .clk(clk), .rst(rst), .swap(frame_start), .two_lane(two_lane),
    .load_len(wcount), .rdata(rdata), .raddr(raddr),
    .lane0(lane0), .lane1(lane1), .frame_mark(frame_mark), .trunc(trunc)
  );
endmodule

// File: rtl/pp_checker.sv
module pp_checker (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic wr_valid,
  input logic frame_mark,
  input logic trunc,
  input logic buf_full
);
  AST_MARK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> frame_mark); // R2
  AST_MARK_ONLY_SWAP: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> !frame_mark); // R10
  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !buf_full); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    buf_full && !frame_start |=> buf_full); // R8
  AST_FULL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !buf_full && !wr_valid |=> !buf_full); // R8
  AST_TRUNC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(trunc)); // R9
endmodule

bind pingpong_serial_buffer pp_checker u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .wr_valid(wr_valid),
  .frame_mark(frame_mark), .trunc(trunc), .buf_full(buf_full)
);

// File: tb/pingpong_serial_buffer_bench.sv
`timescale 1ns/1ps
module pingpong_serial_buffer_bench;
  localparam int          DEPTH = 8;
  localparam logic [15:0] HDR   = 16'hF0C5;
  localparam logic [15:0] PAD   = 16'h3A3A;

  logic clk = 0, rst = 1, frame_start = 0, wr_valid = 0, two_lane = 0;
  logic [15:0] wr_data = '0;
  logic lane0, lane1, frame_mark, trunc, buf_full;

  int total = 0, bad = 0;
  int fnum = 0;
  logic [15:0] expq[$], nextq[$], pend[$];

  always #2.5 clk = ~clk;

  pingpong_serial_buffer #(.DEPTH(DEPTH)) u_pingpong_serial_buffer (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .two_lane(two_lane), .lane0(lane0), .lane1(lane1),
    .frame_mark(frame_mark), .trunc(trunc), .buf_full(buf_full)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: raises a marker, queues the expected framed record, then writes
  task automatic do_frame(input int nwr, input bit mode, input int gap, input bit mark_wr);
    int stored;
    @(negedge clk);
    frame_start = 1; two_lane = mode;
    fnum++;
    stored = pend.size();
    nextq.delete();
    nextq.push_back(HDR);
    nextq.push_back(16'(fnum));
    for (int i = 0; i < stored; i++) nextq.push_back(pend[i]);
    nextq.push_back({4'hE, 12'(stored)});
    pend.delete();
    wr_valid = mark_wr;
    if (mark_wr) begin // R4: write in the marker cycle opens the new bank
      wr_data = 16'($urandom);
      pend.push_back(wr_data);
    end
    @(negedge clk);
    frame_start = 0;
    wr_valid = 0;
    for (int i = 0; i < nwr; i++) begin
      wr_valid = 1;
      wr_data = 16'($urandom);
      if (pend.size() < DEPTH) pend.push_back(wr_data);
      @(negedge clk);
    end
    wr_valid = 0;
    if (nwr + int'(mark_wr) > DEPTH) check(buf_full == 1'b1, "R8 full set", buf_full, 1);
    else check(buf_full == 1'b0, "R8 full clear", buf_full, 0);
    repeat (gap) @(negedge clk);
  endtask

  // monitor: rebuilds words from the lanes and compares with the scoreboard
  bit synced = 0, mmode = 0, l1 = 0, prev_mark = 0;
  logic [15:0] acc = '0;
  int nb = 0, widx = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_mark) check(frame_mark == 1'b0, "R10", frame_mark, 0);
      prev_mark = frame_mark;
      if (frame_mark) begin
        check(trunc == (expq.size() != 0), "R9", trunc, int'(expq.size() != 0));
        expq = nextq;
        nextq.delete();
        synced = 1; mmode = two_lane; acc = '0; nb = 0; l1 = 0; widx = 0;
      end
      if (synced) begin
        if (mmode) begin
          acc = {acc[13:0], lane1, lane0};
          nb += 2;
        end else begin
          acc = {acc[14:0], lane0};
          nb += 1;
          l1 |= lane1;
        end
        if (nb == 16) begin
          if (!mmode) check(!l1, "R6 lane1 idle", l1, 0);
          if (expq.size() != 0) begin
            logic [15:0] e;
            e = expq.pop_front();
            if (widx == 0) check(acc == e, "R2", acc, e);
            else if (mmode) check(acc == e, "R7 R3", acc, e);
            else check(acc == e, "R6 R3", acc, e);
          end else begin
            check(acc == PAD, "R5", acc, PAD);
          end
          widx++; nb = 0; acc = '0; l1 = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check(lane0 == 0 && lane1 == 0, "R1 lanes", {lane1, lane0}, 0);
    check(frame_mark == 0, "R1 mark", frame_mark, 0);
    check(trunc == 0 && buf_full == 0, "R1 status", {trunc, buf_full}, 0);
    @(negedge clk); rst = 0;
    repeat (10) @(negedge clk);
    do_frame(0, 0, 80, 0);   // empty record, one lane
    do_frame(5, 0, 150, 0);  // R3 stored words follow in next frame
    do_frame(3, 1, 150, 1);  // R7 two lanes, R4 write with marker
    do_frame(11, 1, 150, 0); // R8 overflow
    do_frame(2, 0, 250, 0);  // R8 trailer reports DEPTH
    do_frame(8, 0, 100, 0);
    do_frame(0, 0, 20, 0);   // marker too early next: R9 cut
    do_frame(0, 1, 100, 0);
    do_frame(0, 1, 80, 0);   // clean swap again, R9 clear
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule